// File: doc/BRIEF.md
# Mailbox Boot Loader Responder

This block is the coprocessor side of a byte-wide upload handshake carried over four 8-bit mailbox registers written by a host. After reset it shows a fixed two-byte signature on its echo registers. The host then asks for a transfer by writing a start code to mailbox 0, with a 16-bit destination address split across mailboxes 2 (low byte) and 3 (high byte). Each data byte is offered on mailbox 1 together with a running index on mailbox 0. When the index is the one the responder expects, the responder writes the byte into local RAM through a simple write port, steps its own pointer and echoes the index back. The host learns that the byte has landed by reading that echo.

No length is sent. The host ends a block by writing an index that has jumped ahead of the expected one. The responder detects this from the sign bit of the 8-bit difference between the expected and the written index. It then takes a fresh address from mailboxes 2/3. If mailbox 1 is zero, that address becomes a held execute request for a processor elsewhere. If mailbox 1 is nonzero, a new block starts at that address. The responder polls the mailbox levels on every clock, so a value that stays in a mailbox does no harm once it has been consumed.

Top module: `bl_mailbox_responder`

## Requirements
- R1: While `rst_n` is low at a rising edge, from the next cycle on `echo_p0` = 0xAA, `echo_p1` = 0xBB, `ram_we` = 0 and `exec_req` = 0.
- R2: In the signature state, a mailbox 0 value of 0xCC captures {mailbox 3, mailbox 2} as the RAM pointer. One cycle later `echo_p0` = 0xCC and `echo_p1` = 0x00. Any other mailbox 0 value is ignored.
- R3: Every block starts with an expected index of 0x00. Until the first byte is taken, only a mailbox 0 value of exactly 0x00 has any effect, and stale or larger values are ignored.
- R4: When mailbox 0 equals the expected index k, then in the next cycle `ram_we` is high for one cycle with `ram_addr` = pointer and `ram_wdata` = mailbox 1, and `echo_p0` = k. The pointer then advances by one and the expected index becomes k+1.
- R5: After at least one byte of a block, a mailbox 0 value v with bit 7 of (k − v) mod 256 set ends the block (for example k = 0x0A, v = 0x0B). The next cycle `echo_p0` = v, no write occurs, {mailbox 3, mailbox 2} is captured and the index returns to 0x00.
- R6: At end of block with mailbox 1 = 0x00, `exec_req` rises with `exec_addr` = {mailbox 3, mailbox 2}. It holds both until reset, and all mailbox values are ignored meanwhile.
- R7: At end of block with mailbox 1 ≠ 0x00, a new block starts at the captured address, following R3.
- R8: During a block, a mailbox 0 value v ≠ k with bit 7 of (k − v) mod 256 clear is ignored: no write and `echo_p0` unchanged. This includes v = k + 0x81.
- R9: A reset while `exec_req` is high drops the request and brings back the signature state.
- R10: The RAM pointer wraps from 0xFFFF to 0x0000 within a block.
- R11: The expected index wraps from 0xFF to 0x00 within a block, so a block may exceed 256 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_p0 | input | 8 | Mailbox 0 as written by the host: start code or byte index |
| host_p1 | input | 8 | Mailbox 1: data byte, or block/execute selector at end of block |
| host_p2 | input | 8 | Mailbox 2: address low byte |
| host_p3 | input | 8 | Mailbox 3: address high byte |
| echo_p0 | output | 8 | Echo for mailbox 0: signature, start code or index |
| echo_p1 | output | 8 | Echo for mailbox 1: signature, then zero |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | ADDR_W | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| exec_req | output | 1 | Held execute request |
| exec_addr | output | ADDR_W | Entry address of the execute request |

## Verification
The bench builds the responder with its default parameters: a 16-bit address and the 0xAA/0xBB signature with a 0xCC start code. Only the full 16-bit address makes the pointer wrap at 0xFFFF reachable, and a block of more than 256 bytes lets the 8-bit index roll over inside one transfer. The default widths also bring within reach the boundary pair around the sign test: an index jump of exactly 0x80 ends a block, while a jump of 0x81 leaves a difference of 0x7F and is ignored.

// File: rtl/bl_mailbox_pkg.sv
// Shared types for the mailbox boot loader responder.
// Assumes: one state register in the top module uses this enum.
package bl_mailbox_pkg;

    // Protocol phase of the responder.
    typedef enum logic [1:0] {
        ST_SIG  = 2'd0,   // signature shown, waiting for start code
        ST_ARM  = 2'd1,   // block opened, waiting for index 0
        ST_XFER = 2'd2,   // bytes flowing, end detection active
        ST_RUN  = 2'd3    // execute request held until reset
    } bl_state_t;

endpackage

// File: rtl/bl_index_ctr.sv
// Expected-index counter of the responder.
// Clears to zero at reset or on request, and steps by one on request.
// Assumes: clr and inc are never asserted together by the caller.
module bl_index_ctr #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [IDX_W-1:0] idx
);

    // Hold, clear or step the expected index.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            idx <= '0;
        end else if (inc) begin
            idx <= idx + 1'b1;
        end
    end

endmodule

// File: rtl/bl_index_cmp.sv
// Compares the host index with the expected index.
// hit:  the host offers exactly the expected byte.
// past: the host index lies ahead, because the sign bit of
//       (expected - host) is set, taken modulo 2**IDX_W.
// Assumes: purely combinational, inputs are registered or stable levels.
module bl_index_cmp #(
    parameter int IDX_W = 8
) (
    input  logic [IDX_W-1:0] expected,
    input  logic [IDX_W-1:0] host_idx,
    output logic             hit,
    output logic             past
);

    localparam logic [IDX_W-1:0] SIGN_MASK = {1'b1, {(IDX_W-1){1'b0}}};

    logic [IDX_W-1:0] gap;

    // Difference of the two indices and its sign.
    always_comb begin
        gap  = expected - host_idx;
        hit  = (gap == '0);
        past = ((gap & SIGN_MASK) != '0);
    end

endmodule

// File: rtl/bl_ptr_reg.sv
// RAM pointer kept inside the responder.
// Loads a new address or post-increments, wrapping at 2**ADDR_W.
// Assumes: load takes priority over inc.
module bl_ptr_reg #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              inc,
    output logic [ADDR_W-1:0] ptr
);

    // Hold, load or step the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_val;
        end else if (inc) begin
            ptr <= ptr + 1'b1;
        end
    end

endmodule

// File: rtl/bl_mailbox_responder.sv
// Mailbox boot loader responder, top level.
// Polls four host-written mailbox levels every clock, shows a signature,
// takes a destination address, stores indexed bytes through a RAM write
// port, and ends a block when the host index jumps ahead of the expected
// one. At end of block a zero selector raises a held execute request,
// and a nonzero selector opens a new block.
// Assumes: the host keeps each mailbox level stable until it sees the echo,
// and ADDR_W is at most 16. All outputs are registered.
module bl_mailbox_responder #(
    parameter int          ADDR_W     = 16,
    parameter logic [7:0]  SIG_LO     = 8'hAA,
    parameter logic [7:0]  SIG_HI     = 8'hBB,
    parameter logic [7:0]  START_CODE = 8'hCC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        host_p0,
    input  logic [7:0]        host_p1,
    input  logic [7:0]        host_p2,
    input  logic [7:0]        host_p3,
    output logic [7:0]        echo_p0,
    output logic [7:0]        echo_p1,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [7:0]        ram_wdata,
    output logic              exec_req,
    output logic [ADDR_W-1:0] exec_addr
);
    import bl_mailbox_pkg::*;

    localparam int IDX_W = 8;

    bl_state_t         st, st_nxt;
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] ptr;
    logic [ADDR_W-1:0] host_addr;
    logic              idx_hit, idx_past;
    logic              ptr_load, ptr_inc, idx_clr, idx_inc;
    logic              take_byte, end_block, go_exec;

    assign host_addr = ADDR_W'({host_p3, host_p2});

    bl_index_ctr #(.IDX_W(IDX_W)) i_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (idx_clr),
        .inc   (idx_inc),
        .idx   (idx)
    );

    bl_index_cmp #(.IDX_W(IDX_W)) i_cmp (
        .expected (idx),
        .host_idx (host_p0),
        .hit      (idx_hit),
        .past     (idx_past)
    );

    bl_ptr_reg #(.ADDR_W(ADDR_W)) i_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_val (host_addr),
        .inc      (ptr_inc),
        .ptr      (ptr)
    );

    // Decide this cycle's protocol action from state and mailbox levels.
    always_comb begin
        st_nxt    = st;
        take_byte = 1'b0;
        end_block = 1'b0;
        go_exec   = 1'b0;
        ptr_load  = 1'b0;
        idx_clr   = 1'b0;
        unique case (st)
            ST_SIG: begin
                if (host_p0 == START_CODE) begin
                    ptr_load = 1'b1;
                    idx_clr  = 1'b1;
                    st_nxt   = ST_ARM;
                end
            end
            ST_ARM: begin
                if (idx_hit) begin
                    take_byte = 1'b1;
                    st_nxt    = ST_XFER;
                end
            end
            ST_XFER: begin
                if (idx_hit) begin
                    take_byte = 1'b1;
                end else if (idx_past) begin
                    end_block = 1'b1;
                    ptr_load  = 1'b1;
                    idx_clr   = 1'b1;
                    go_exec   = (host_p1 == 8'h00);
                    st_nxt    = go_exec ? ST_RUN : ST_ARM;
                end
            end
            ST_RUN: begin
                st_nxt = ST_RUN;
            end
            default: st_nxt = ST_SIG;
        endcase
        ptr_inc = take_byte;
        idx_inc = take_byte;
    end

    // Protocol state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_SIG;
        end else begin
            st <= st_nxt;
        end
    end

    // Echo registers: signature, start code, then index echoes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            echo_p0 <= SIG_LO;
            echo_p1 <= SIG_HI;
        end else if (st == ST_SIG && host_p0 == START_CODE) begin
            echo_p0 <= START_CODE;
            echo_p1 <= 8'h00;
        end else if (take_byte || end_block) begin
            echo_p0 <= host_p0;
        end
    end

    // RAM write port: one-cycle strobe per accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_we    <= 1'b0;
            ram_addr  <= '0;
            ram_wdata <= 8'h00;
        end else begin
            ram_we <= take_byte;
            if (take_byte) begin
                ram_addr  <= ptr;
                ram_wdata <= host_p1;
            end
        end
    end

    // Execute request: raised at a zero-selector end, held until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exec_req  <= 1'b0;
            exec_addr <= '0;
        end else if (go_exec) begin
            exec_req  <= 1'b1;
            exec_addr <= host_addr;
        end
    end

endmodule

// File: rtl/bl_mailbox_responder_chk.sv
// Protocol checker for the mailbox boot loader responder, attached by bind.
// Assumes: the same parameters as the bound instance.
module bl_mailbox_responder_chk #(
    parameter int         ADDR_W = 16,
    parameter logic [7:0] SIG_LO = 8'hAA,
    parameter logic [7:0] SIG_HI = 8'hBB
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        host_p0,
    input logic [7:0]        host_p1,
    input logic [7:0]        echo_p0,
    input logic [7:0]        echo_p1,
    input logic              ram_we,
    input logic [7:0]        ram_wdata,
    input logic              exec_req,
    input logic [ADDR_W-1:0] exec_addr
);

    // R1: a reset edge leaves the signature and no activity behind.
    a_r1_signature: assert property (@(posedge clk)
        !rst_n |=> (echo_p0 == SIG_LO && echo_p1 == SIG_HI && !ram_we && !exec_req));

    // R4: written data is the mailbox 1 byte seen at the accepting edge.
    a_r4_wdata_from_p1: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> ram_wdata == $past(host_p1));

    // R4: the echo carries the accepted index.
    a_r4_echo_index: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> echo_p0 == $past(host_p0));

    // R6: the execute request holds until reset.
    a_r6_exec_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        exec_req |=> exec_req);

    // R6: the entry address does not move while the request is held.
    a_r6_exec_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        exec_req |=> $stable(exec_addr));

    // R6: no RAM write while an execute request is pending.
    a_r6_no_write_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        exec_req |-> !ram_we);

endmodule

bind bl_mailbox_responder bl_mailbox_responder_chk #(
    .ADDR_W (ADDR_W),
    .SIG_LO (SIG_LO),
    .SIG_HI (SIG_HI)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_p0   (host_p0),
    .host_p1   (host_p1),
    .echo_p0   (echo_p0),
    .echo_p1   (echo_p1),
    .ram_we    (ram_we),
    .ram_wdata (ram_wdata),
    .exec_req  (exec_req),
    .exec_addr (exec_addr)
);

// File: tb/test_bl_mailbox_responder.sv
// Bench: behavioural reference of the upload handshake, compared every cycle.
module test_bl_mailbox_responder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  p0 = 8'h00, p1 = 8'h00, p2 = 8'h00, p3 = 8'h00;
    logic [7:0]  echo_p0, echo_p1, ram_wdata;
    logic        ram_we, exec_req;
    logic [15:0] ram_addr, exec_addr;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    string phase = "R1 reset";

    always #2 clk = ~clk;   // 250 MHz

    bl_mailbox_responder i_bl_mailbox_responder (
        .clk(clk), .rst_n(rst_n),
        .host_p0(p0), .host_p1(p1), .host_p2(p2), .host_p3(p3),
        .echo_p0(echo_p0), .echo_p1(echo_p1),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .exec_req(exec_req), .exec_addr(exec_addr)
    );

    // Reference model state (behavioural integers).
    int m_st = 0, m_k = 0, m_ptr = 0;
    int m_e0 = 'hAA, m_e1 = 'hBB, m_we = 0, m_addr = 0, m_data = 0;
    int m_exec = 0, m_xaddr = 0;
    int writes_seen = 0;

    always @(posedge clk) begin
        int a;
        a = {p3, p2};
        if (!rst_n) begin
            m_st = 0; m_k = 0; m_ptr = 0; m_e0 = 'hAA; m_e1 = 'hBB;
            m_we = 0; m_exec = 0; m_xaddr = 0; m_addr = 0; m_data = 0;
        end else begin
            m_we = 0;
            if (m_st == 0) begin
                if (p0 == 8'hCC) begin
                    m_ptr = a; m_k = 0; m_e0 = 'hCC; m_e1 = 0; m_st = 1;
                end
            end else if (m_st == 1 || m_st == 2) begin
                if (p0 == m_k) begin
                    m_we = 1; m_addr = m_ptr; m_data = p1; m_e0 = p0;
                    m_ptr = (m_ptr + 1) % 65536; m_k = (m_k + 1) % 256;
                    m_st = 2; writes_seen++;
                end else if (m_st == 2 && ((m_k - p0 + 256) % 256) >= 128) begin
                    m_e0 = p0; m_ptr = a; m_k = 0;
                    if (p1 == 0) begin m_exec = 1; m_xaddr = a; m_st = 3; end
                    else m_st = 1;
                end
            end
        end
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: %s actual=%0h expected=%0h", phase, what, act, exp);
        end
    endtask

    // Compare every output against the reference away from the clock edge.
    always @(negedge clk) begin
        cycles++;
        check(echo_p0 == m_e0, "echo_p0", echo_p0, m_e0);
        check(echo_p1 == m_e1, "echo_p1", echo_p1, m_e1);
        check(ram_we == m_we, "ram_we", ram_we, m_we);
        if (m_we != 0) begin
            check(ram_addr == m_addr, "ram_addr", ram_addr, m_addr);
            check(ram_wdata == m_data, "ram_wdata", ram_wdata, m_data);
        end
        check(exec_req == m_exec, "exec_req", exec_req, m_exec);
        if (m_exec != 0) check(exec_addr == m_xaddr, "exec_addr", exec_addr, m_xaddr);
        if (cycles > 150000) begin
            check(1'b0, "watchdog expired", cycles, 150000);
            finish_run();
        end
    end

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Drive all four mailboxes after a falling edge and hold for n cycles.
    task automatic put(input logic [7:0] a0, input logic [7:0] a1,
                       input logic [7:0] a2, input logic [7:0] a3, input int n);
        @(negedge clk);
        p0 = a0; p1 = a1; p2 = a2; p3 = a3;
        repeat (n) @(negedge clk);
    endtask

    // Send one indexed data byte.
    task automatic send(input logic [7:0] idx, input logic [7:0] d);
        put(idx, d, p2, p3, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(echo_p0 == 8'hAA && echo_p1 == 8'hBB, "R1 signature literal", echo_p0, 'hAA);

        phase = "R2 idle ignore and start";
        put(8'h00, 8'h11, 8'h00, 8'h00, 2);
        put(8'h55, 8'h22, 8'h00, 8'h00, 2);
        check(echo_p0 == 8'hAA, "R2 stray value ignored", echo_p0, 'hAA);
        put(8'hCC, 8'h01, 8'hF0, 8'h12, 2);
        check(echo_p0 == 8'hCC && echo_p1 == 8'h00, "R2 start echo", echo_p0, 'hCC);

        phase = "R3 first byte wait";
        put(8'h07, 8'h33, 8'hF0, 8'h12, 3);
        put(8'h05, 8'h33, 8'hF0, 8'h12, 3);
        check(writes_seen == 0, "R3 no write before index 0", writes_seen, 0);

        phase = "R4 byte stream";
        for (int i = 0; i < 5; i++) send(8'(i), 8'(8'h40 + i));
        check(writes_seen == 5, "R4 five bytes written", writes_seen, 5);

        phase = "R8 stale index ignored";
        send(8'h02, 8'h99);
        send(8'h86, 8'h99);   // k=5: gap 0x7F, positive
        check(writes_seen == 5 && echo_p0 == 8'h04, "R8 no effect", echo_p0, 'h04);

        phase = "R5 R7 end block, new block";
        put(8'h07, 8'h44, 8'hFE, 8'hFF, 3);
        check(echo_p0 == 8'h07 && !exec_req, "R5 echo end index", echo_p0, 'h07);

        phase = "R3 R10 new block with pointer wrap";
        put(8'h07, 8'h44, 8'hFE, 8'hFF, 2);
        for (int i = 0; i < 4; i++) send(8'(i), 8'(8'hA0 + i));

        phase = "R11 index wrap";
        put(8'h10, 8'h01, 8'h00, 8'h20, 3);
        for (int i = 0; i < 260; i++) send(8'(i % 256), 8'(i * 3));
        check(writes_seen == 269, "R11 long block count", writes_seen, 269);

        phase = "R5 end at jump of 0x80";
        put(8'h84, 8'h01, 8'h00, 8'h30, 3);   // k=4: gap 0x80, negative
        check(echo_p0 == 8'h84, "R5 boundary end", echo_p0, 'h84);
        send(8'h00, 8'h5A);

        phase = "R6 execute";
        put(8'h03, 8'h00, 8'h00, 8'h04, 3);
        check(exec_req && exec_addr == 16'h0400, "R6 exec literal", exec_addr, 'h0400);
        put(8'hCC, 8'h00, 8'h11, 8'h22, 3);
        put(8'h00, 8'h77, 8'h11, 8'h22, 3);
        check(exec_req && exec_addr == 16'h0400 && !ram_we, "R6 ports ignored", exec_addr, 'h0400);

        phase = "R9 reset drops exec";
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check(!exec_req && echo_p0 == 8'hAA, "R9 signature back", exec_req, 0);

        phase = "R6 short session";
        put(8'hCC, 8'h00, 8'h00, 8'h05, 2);
        send(8'h00, 8'hEE);
        put(8'h02, 8'h00, 8'h34, 8'h12, 3);
        check(exec_req && exec_addr == 16'h1234, "R6 second exec", exec_addr, 'h1234);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule